// File: doc/BRIEF.md
# Evaluate-Update Statement Cell

This block is the hardware stand-in for one left-hand-side variable of an event-driven simulation model, mapped onto an emulation clock. Every driver of that variable owns an evaluate register. The evaluate register captures the driver's right-hand-side value on any emulation cycle in which one of the driver's sensitivity events fires. All drivers feed a single shared update register, and that register holds the visible left-hand-side value.

Each driver is marked as blocking or nonblocking at the moment it is evaluated. A blocking driver commits its captured value on the emulation cycle right after the evaluation. A nonblocking driver keeps the value pending until the step-done strobe marks the end of the current simulation time step. The pending mark is then cleared. If several drivers commit on the same edge, the driver with the lowest index wins.

Alongside the value, the cell outputs a change event. The event is one emulation cycle wide. It is made by XOR of the value with a copy of itself delayed by one cycle, so other cells can use it as a sensitivity input.

Top module: `evup_cell`

## Requirements
- R1: While reset (rstN low) is held and after it is released, lhsVal is 0 and lhsEvt is 0 until the first update.
- R2: A driver's evaluate register loads that driver's rhsVal slice (bits i*WIDTH up to i*WIDTH+WIDTH-1 for driver i) only on a rising edge where the driver has a sensitivity event. Changes to rhsVal with no event never reach lhsVal, even across a step-done strobe.
- R3: A driver evaluated with nonBlk bit 0 (blocking) on edge k drives its captured value onto lhsVal at edge k+1.
- R4: A driver evaluated with nonBlk bit 1 (nonblocking) leaves lhsVal unchanged until the first rising edge with stepDone high, and lhsVal takes the captured value at that edge.
- R5: A nonblocking update is applied at most once: once a step-done edge has consumed the pending mark, later stepDone pulses do not re-apply it.
- R6: lhsEvt is high for exactly the one cycle after each edge at which lhsVal changes, and stays low when an update writes the value already held.
- R7: Every driver can load the shared update register, and the register holds whatever the most recent applied update wrote.
- R8: When several drivers' updates fall on the same edge, lhsVal takes the value of the lowest-indexed of them.
- R9: When a nonblocking driver is evaluated again before step done, the later captured value is the one applied.
- R10: Driver i is evaluated when any of its NSENS sensitivity bits (sensEvt bits i*NSENS up to i*NSENS+NSENS-1) is high at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock; every operation happens on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sensEvt | input | NDRV*NSENS | Sensitivity event pulses, NSENS bits per driver |
| rhsVal | input | NDRV*WIDTH | Right-hand-side value of each driver |
| nonBlk | input | NDRV | Assignment kind per driver: 1 nonblocking, 0 blocking |
| stepDone | input | 1 | End of the current simulation time step |
| lhsVal | output | WIDTH | Committed left-hand-side value |
| lhsEvt | output | 1 | One-cycle pulse after lhsVal changes |

## Verification
An evaluation on edge k has these results:
- For a blocking driver, lhsVal is due right after edge k+1.
- For a nonblocking driver, lhsVal is due right after the first edge with stepDone high.
- lhsEvt is high only in the cycle that follows the change, and low again one edge later.

The bench drives inputs on the falling edge and samples outputs on the next falling edge. It counts edges from the evaluating one and checks lhsVal as still unchanged before the commit edge and as updated right after it. Race cases place updates from several drivers on one edge, including a blocking commit that coincides with a step-done strobe.

// File: rtl/evup_pkg.sv
package evup_pkg;
  // Upper bound on drivers sharing one update register
  parameter int DRV_MAX = 8;
  localparam int IDX_W = $clog2(DRV_MAX);

  // Strobes passed from control to datapath
  typedef struct packed {
    logic             updAny;  // some driver commits this edge
    logic [IDX_W-1:0] updIdx;  // winning driver
  } evupStrobes_t;
endpackage

// File: rtl/evup_ctl.sv
module evup_ctl
  import evup_pkg::*;
#(
  parameter int NDRV  = 3,
  parameter int NSENS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NDRV*NSENS-1:0] sensEvt,
  input  logic [NDRV-1:0]       nonBlk,
  input  logic                  stepDone,
  output logic [NDRV-1:0]       evalEn,
  output evupStrobes_t          strb
);
  logic [NDRV-1:0] pendBlk;
  logic [NDRV-1:0] pendNb;
  logic [NDRV-1:0] updTrig;
  logic [NDRV-1:0] nbEval;

  // Evaluate trigger: any sensitivity event of the driver
  for (genvar g = 0; g < NDRV; g++) begin : g_trig
    assign evalEn[g] = |sensEvt[g*NSENS +: NSENS];
  end

  assign nbEval = evalEn & nonBlk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendBlk <= '0;
      pendNb  <= '0;
    end else begin
      pendBlk <= evalEn & ~nonBlk;
      if (stepDone) pendNb <= nbEval;
      else          pendNb <= pendNb | nbEval;
    end
  end

  assign updTrig = pendBlk | (pendNb & {NDRV{stepDone}});

  // Fixed priority: lowest index wins a race
  always_comb begin
    strb.updAny = |updTrig;
    strb.updIdx = '0;
    for (int i = NDRV - 1; i >= 0; i--) begin
      if (updTrig[i]) strb.updIdx = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < NDRV; g++) begin : g_chk
    // R3
    blkNext_chk: assert property (@(posedge clk) disable iff (!rstN)
      (evalEn[g] && !nonBlk[g]) |=> strb.updAny);
  end

  // R4
  nbHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(|(evalEn & ~nonBlk)) ##1 !stepDone) |-> !strb.updAny);
endmodule

// File: rtl/evup_dp.sv
module evup_dp
  import evup_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NDRV  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NDRV*WIDTH-1:0] rhsVal,
  input  logic [NDRV-1:0]       evalEn,
  input  evupStrobes_t          strb,
  output logic [WIDTH-1:0]      lhsVal,
  output logic                  lhsEvt
);
  logic [WIDTH-1:0] evalReg [NDRV];
  logic [WIDTH-1:0] selVal;
  logic [WIDTH-1:0] updReg;
  logic [WIDTH-1:0] lhsPrev;

  // Evaluate registers, one per driver
  for (genvar g = 0; g < NDRV; g++) begin : g_eval
    always_ff @(posedge clk) begin
      if (!rstN)          evalReg[g] <= '0;
      else if (evalEn[g]) evalReg[g] <= rhsVal[g*WIDTH +: WIDTH];
    end
  end

  always_comb begin
    selVal = '0;
    for (int i = 0; i < NDRV; i++) begin
      if (strb.updIdx == IDX_W'(i)) selVal = evalReg[i];
    end
  end

  // Shared update register and change detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      updReg  <= '0;
      lhsPrev <= '0;
    end else begin
      if (strb.updAny) updReg <= selVal;
      lhsPrev <= updReg;
    end
  end

  assign lhsVal = updReg;
  assign lhsEvt = |(updReg ^ lhsPrev);

  // R7
  updLoad_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.updAny |=> (lhsVal == $past(selVal)));

  // R6
  idleNoEvt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.updAny |=> !lhsEvt);
endmodule

// File: rtl/evup_cell.sv
module evup_cell
  import evup_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NDRV  = 3,
  parameter int NSENS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NDRV*NSENS-1:0] sensEvt,
  input  logic [NDRV*WIDTH-1:0] rhsVal,
  input  logic [NDRV-1:0]       nonBlk,
  input  logic                  stepDone,
  output logic [WIDTH-1:0]      lhsVal,
  output logic                  lhsEvt
);
  logic [NDRV-1:0] evalEn;
  evupStrobes_t    strb;

  evup_ctl #(.NDRV(NDRV), .NSENS(NSENS)) u_ctl (
    .clk(clk), .rstN(rstN), .sensEvt(sensEvt), .nonBlk(nonBlk),
    .stepDone(stepDone), .evalEn(evalEn), .strb(strb)
  );

  evup_dp #(.WIDTH(WIDTH), .NDRV(NDRV)) u_dp (
    .clk(clk), .rstN(rstN), .rhsVal(rhsVal), .evalEn(evalEn),
    .strb(strb), .lhsVal(lhsVal), .lhsEvt(lhsEvt)
  );

  // R1
  rstQuiet_chk: assert property (@(posedge clk)
    !rstN |=> (lhsVal == '0 && !lhsEvt));
endmodule

// File: tb/evup_cell_tb.sv
`timescale 1ns/1ps
module evup_cell_tb;
  localparam int W = 8;
  localparam int ND = 3;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ND*NS-1:0] sensEvt = '0;
  logic [ND*W-1:0] rhsVal = '0;
  logic [ND-1:0] nonBlk = '0;
  logic stepDone = 1'b0;
  logic [W-1:0] lhsVal;
  logic lhsEvt;

  int checks = 0;
  int failures = 0;
  int expLhs = 0;

  always #2.5 clk = ~clk;

  evup_cell #(.WIDTH(W), .NDRV(ND), .NSENS(NS)) u_dut (
    .clk(clk), .rstN(rstN), .sensEvt(sensEvt), .rhsVal(rhsVal),
    .nonBlk(nonBlk), .stepDone(stepDone), .lhsVal(lhsVal), .lhsEvt(lhsEvt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkLhs(input string req, input int exp);
    chk(int'(lhsVal) == exp, req, int'(lhsVal), exp);
  endtask

  task automatic chkEvt(input string req, input int exp);
    chk(int'(lhsEvt) == exp, req, int'(lhsEvt), exp);
  endtask

  // Blocking write: eval at edge k, commit at edge k+1
  task automatic blkWrite(input int d, input int s, input int v);
    @(negedge clk);
    rhsVal[d*W +: W] = W'(v);
    nonBlk[d] = 1'b0;
    sensEvt[d*NS + s] = 1'b1;
    @(negedge clk);
    sensEvt = '0;
    chkLhs("R3 before commit", expLhs);
    chkEvt("R6 no early event", 0);
    @(negedge clk);
    chkLhs("R3/R10 committed", v);
    chkEvt("R6 change pulse", (v != expLhs) ? 1 : 0);
    expLhs = v;
    @(negedge clk);
    chkEvt("R6 pulse one cycle", 0);
  endtask

  task automatic nbEval(input int d, input int v);
    @(negedge clk);
    rhsVal[d*W +: W] = W'(v);
    nonBlk[d] = 1'b1;
    sensEvt[d*NS] = 1'b1;
    @(negedge clk);
    sensEvt = '0;
  endtask

  task automatic idleHold(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chkLhs(req, expLhs);
    end
  endtask

  task automatic stepPulse(input int v);
    stepDone = 1'b1;
    @(negedge clk);
    stepDone = 1'b0;
    chkLhs("R4 applied at step done", v);
    chkEvt("R6 nb change pulse", (v != expLhs) ? 1 : 0);
    expLhs = v;
    @(negedge clk);
    chkEvt("R6 nb pulse one cycle", 0);
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkLhs("R1 reset value", 0);
    chkEvt("R1 reset event", 0);
    rstN = 1'b1;
    @(negedge clk);
    chkLhs("R1 after release", 0);
    chkEvt("R1 after release event", 0);

    // R7 R10 sweep of every driver and every sensitivity bit
    for (int d = 0; d < ND; d++)
      for (int s = 0; s < NS; s++)
        for (int k = 0; k < 3; k++)
          blkWrite(d, s, (d*37 + s*11 + k*53 + 1) & 255);

    // R6 same value: no pulse
    blkWrite(1, 0, expLhs);

    // R2 rhs changes without events are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rhsVal = ND*W'(k*91 + 7);
      chkLhs("R2 no event no change", expLhs);
    end
    stepDone = 1'b1;
    @(negedge clk);
    stepDone = 1'b0;
    @(negedge clk);
    chkLhs("R2 step done without eval", expLhs);

    // R4 nonblocking with varying gaps, each driver
    for (int d = 0; d < ND; d++) begin
      nbEval(d, (d*29 + 100) & 255);
      idleHold(d + 1, "R4 held until step done");
      stepPulse((d*29 + 100) & 255);
    end

    // R5 pending cleared once applied
    nbEval(1, 200);
    stepPulse(200);
    blkWrite(0, 0, 17);
    stepDone = 1'b1;
    @(negedge clk);
    stepDone = 1'b0;
    @(negedge clk);
    chkLhs("R5 no re-apply", 17);

    // R9 later nonblocking evaluation wins
    nbEval(2, 55);
    nbEval(2, 66);
    idleHold(1, "R9 held");
    stepPulse(66);

    // R8 blocking race, two pairs
    @(negedge clk);
    rhsVal[1*W +: W] = 8'd81; rhsVal[2*W +: W] = 8'd82; nonBlk = '0;
    sensEvt[1*NS] = 1'b1; sensEvt[2*NS + 1] = 1'b1;
    @(negedge clk); sensEvt = '0;
    @(negedge clk); chkLhs("R8 d1 beats d2", 81); expLhs = 81;
    @(negedge clk);
    rhsVal[0*W +: W] = 8'd90; rhsVal[2*W +: W] = 8'd92;
    sensEvt[0] = 1'b1; sensEvt[2*NS] = 1'b1;
    @(negedge clk); sensEvt = '0;
    @(negedge clk); chkLhs("R8 d0 beats d2", 90); expLhs = 90;

    // R8 nonblocking race
    @(negedge clk);
    rhsVal[1*W +: W] = 8'd111; rhsVal[2*W +: W] = 8'd122; nonBlk = 3'b110;
    sensEvt[1*NS] = 1'b1; sensEvt[2*NS] = 1'b1;
    @(negedge clk); sensEvt = '0;
    stepPulse(111);

    // R8 mixed: d1 nonblocking pending, d2 blocking commits at step-done edge
    nbEval(1, 133);
    @(negedge clk);
    rhsVal[2*W +: W] = 8'd144; nonBlk[2] = 1'b0; sensEvt[2*NS] = 1'b1;
    @(negedge clk); sensEvt = '0;
    stepPulse(133);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule